// File: doc/BRIEF.md
# System Reset Sequencer

This block sits in the always-on slow clock domain. It merges the chip's reset causes into one ordered release of the processor. There are three causes. The first is power-on, which is the OR of a coarse supply detector and a precise supply detector. The second is an active-high external reset pin. The third is an expiry pulse from the watchdog counter. The block drives three outputs from a small state machine:

- a CPU reset,
- an internal system-reset strobe,
- the power-down control of the main oscillator.

The timing depends on the cause. A supply or pin reset holds the system reset for one cycle after the source goes away. It then waits through a long low-power hold-off with the oscillator off. Last, it gives one cycle with the oscillator running before the CPU starts. A watchdog reset leaves the oscillator running and lets the CPU go after two cycles.

The block also owns the watchdog-enable state. Software arms it with a one-cycle strobe, which is the effect of clearing the status bit. Software cannot turn it off again. Only a supply or pin reset clears it. Three cause flags report which source produced the last reset. The detector and pin inputs are brought into the slow clock through a synchronizer. A supply detector assertion also resets every flop in the block at once.

Top module: `rst_seq_ctrl`

## Requirements
- R1: A high level on either supply detector input, alone, asserts cpu_rst_o, sys_rst_o and osc_pd_o. All three stay high while the detector stays high.
- R2: A high level on ext_rst_i produces the same sequence as a supply reset. The effect appears SYNC_STAGES+1 cycles after the level is first sampled. The cause flags then read por=0, ext=1, wdt=0.
- R3: Once the last supply or pin source is removed, sys_rst_o stays high for SYNC_STAGES synchronizer cycles plus exactly one further cycle.
- R4: After sys_rst_o falls, osc_pd_o stays high for exactly HOLDOFF_CYCLES cycles, and cpu_rst_o stays high during them. osc_pd_o is never high while cpu_rst_o is low.
- R5: After the hold-off, there is exactly one cycle with osc_pd_o low and cpu_rst_o high. cpu_rst_o is low from the next cycle on.
- R6: An accepted watchdog expiry raises sys_rst_o for one cycle, starting with the cycle after the pulse is sampled. cpu_rst_o stays high for two cycles. osc_pd_o stays low throughout.
- R7: wdt_en_o reads 0 after any supply or pin reset. A wdt_arm_i strobe sets it. No input other than a supply or pin reset clears it. A watchdog reset leaves it set.
- R8: A watchdog expiry has no effect on any output while wdt_en_o is 0.
- R9: A watchdog expiry that arrives while a reset sequence is in progress is ignored. It neither extends nor repeats the sequence.
- R10: A supply or pin reset that arrives during any phase restarts the full sequence from its beginning. This includes a new full hold-off.
- R11: The cause flags read as follows:
  - After a supply reset: por=1, ext=0, wdt=0. A supply reset clears the watchdog flag.
  - After a watchdog reset: por=0, ext=0, wdt=1.
  - The watchdog flag is never set together with either of the other two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow_i | input | 1 | Slow (32 kHz class) always-on clock |
| por_coarse_i | input | 1 | Coarse supply detector, high = supply low |
| por_fine_i | input | 1 | Precise supply detector, high = supply low |
| ext_rst_i | input | 1 | External reset pin, active high, asynchronous |
| wdt_expire_i | input | 1 | Watchdog expiry pulse, synchronous to clk_slow_i |
| wdt_arm_i | input | 1 | Software strobe that enables the watchdog reset path |
| cpu_rst_o | output | 1 | CPU reset, high while the CPU is held |
| sys_rst_o | output | 1 | Internal system reset strobe |
| osc_pd_o | output | 1 | Main oscillator power-down, high = oscillator off |
| wdt_en_o | output | 1 | Watchdog reset path enabled |
| cause_por_o | output | 1 | Last reset came from a supply detector |
| cause_ext_o | output | 1 | Last reset came from the external pin |
| cause_wdt_o | output | 1 | Last reset came from the watchdog |

## Verification
A wrong sequencer state shows up as an output pattern that is off by at least one cycle. Examples are a hold-off one cycle short or long, an oscillator that is on during reset, or a watchdog reset that lasts three cycles. Every cycle of every sequence is compared against a queue of expected output triples, so a wrong state is reported in the cycle it appears. A wrong enable or cause register is only visible through its own port or through the reaction to the next expiry pulse. These are therefore read after each sequence, and expiry pulses are applied both with the path disabled and during a sequence.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic [2:0] {
        ST_SRC     = 3'd0,   // supply or pin source still active
        ST_SYSRST  = 3'd1,   // one cycle of internal reset after source release
        ST_HOLD    = 3'd2,   // low-power hold-off, oscillator off
        ST_OSCON   = 3'd3,   // one cycle with oscillator running
        ST_RUN     = 3'd4,   // CPU released
        ST_WD_RST  = 3'd5,   // watchdog internal reset cycle
        ST_WD_WAIT = 3'd6    // one extra cycle before CPU release
    } seq_state_e;

    typedef struct packed {
        logic por;
        logic ext;
        logic wdt;
    } cause_t;

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

    typedef struct packed {
        logic   en;
        cause_t cause;
    } status_regs_t;

endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
    parameter int unsigned      WIDTH     = 2,
    parameter int unsigned      STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk_i,
    input  logic             arst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = d_i;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk_i or posedge arst_i) begin
            if (arst_i) stage_q[g] <= RESET_VAL;
            else        stage_q[g] <= stage_d;
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/rsc_timer.sv
module rsc_timer #(
    parameter int unsigned COUNT = 2048
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic load_i,
    input  logic run_i,
    output logic done_o
);

    localparam int unsigned CW = (COUNT > 1) ? $clog2(COUNT) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)                    cnt_d = CW'(COUNT - 1);
        else if (run_i && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/rsc_status.sv
module rsc_status
    import rsc_pkg::*;
(
    input  logic   clk_i,
    input  logic   arst_i,
    input  logic   por_i,
    input  logic   ext_i,
    input  logic   full_seq_i,
    input  logic   wd_fire_i,
    input  logic   arm_i,
    output logic   wdt_en_o,
    output cause_t cause_o
);

    status_regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (por_i || ext_i) begin
            s_d.en = 1'b0;
            if (full_seq_i) begin
                s_d.cause.por = s_q.cause.por | por_i;
                s_d.cause.ext = s_q.cause.ext | ext_i;
            end else begin
                s_d.cause.por = por_i;
                s_d.cause.ext = ext_i;
            end
            s_d.cause.wdt = 1'b0;
        end else begin
            if (arm_i)     s_d.en = 1'b1;
            if (wd_fire_i) s_d.cause = '{por: 1'b0, ext: 1'b0, wdt: 1'b1};
        end
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) s_q <= '{en: 1'b0, cause: '{por: 1'b1, ext: 1'b0, wdt: 1'b0}};
        else        s_q <= s_d;
    end

    assign wdt_en_o = s_q.en;
    assign cause_o  = s_q.cause;

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rsc_pkg::*;
#(
    parameter int unsigned HOLDOFF_CYCLES = 2048,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic clk_slow_i,
    input  logic por_coarse_i,
    input  logic por_fine_i,
    input  logic ext_rst_i,
    input  logic wdt_expire_i,
    input  logic wdt_arm_i,
    output logic cpu_rst_o,
    output logic sys_rst_o,
    output logic osc_pd_o,
    output logic wdt_en_o,
    output logic cause_por_o,
    output logic cause_ext_o,
    output logic cause_wdt_o
);

    localparam logic [1:0] SYNC_RST = 2'b01;   // bit0 supply, bit1 pin

    // Supply detectors reset everything asynchronously; release is synchronized.
    logic       arst;
    logic [1:0] raw_src, sync_src;
    logic       por_s, ext_s, src_s;

    assign arst    = por_coarse_i | por_fine_i;
    assign raw_src = {ext_rst_i, 1'b0};

    rsc_sync #(
        .WIDTH     (2),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (SYNC_RST)
    ) u_sync (
        .clk_i  (clk_slow_i),
        .arst_i (arst),
        .d_i    (raw_src),
        .q_o    (sync_src)
    );

    assign por_s = sync_src[0];
    assign ext_s = sync_src[1];
    assign src_s = por_s | ext_s;

    seq_regs_t r_d, r_q;
    logic      hold_done, hold_load, hold_run;
    logic      wd_fire, full_seq, wdt_en;
    cause_t    cause;

    assign hold_load = (r_q.state == ST_SYSRST);
    assign hold_run  = (r_q.state == ST_HOLD);
    assign full_seq  = (r_q.state == ST_SRC)  || (r_q.state == ST_SYSRST) ||
                       (r_q.state == ST_HOLD) || (r_q.state == ST_OSCON);
    assign wd_fire   = (r_q.state == ST_RUN) && wdt_en && wdt_expire_i && !src_s;

    rsc_timer #(
        .COUNT (HOLDOFF_CYCLES)
    ) u_holdoff (
        .clk_i  (clk_slow_i),
        .arst_i (arst),
        .load_i (hold_load),
        .run_i  (hold_run),
        .done_o (hold_done)
    );

    rsc_status u_status (
        .clk_i      (clk_slow_i),
        .arst_i     (arst),
        .por_i      (por_s),
        .ext_i      (ext_s),
        .full_seq_i (full_seq),
        .wd_fire_i  (wd_fire),
        .arm_i      (wdt_arm_i),
        .wdt_en_o   (wdt_en),
        .cause_o    (cause)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_SRC:     r_d.state = ST_SYSRST;
            ST_SYSRST:  r_d.state = ST_HOLD;
            ST_HOLD:    if (hold_done) r_d.state = ST_OSCON;
            ST_OSCON:   r_d.state = ST_RUN;
            ST_RUN:     if (wd_fire) r_d.state = ST_WD_RST;
            ST_WD_RST:  r_d.state = ST_WD_WAIT;
            ST_WD_WAIT: r_d.state = ST_RUN;
            default:    r_d.state = ST_SRC;
        endcase
        if (src_s) r_d.state = ST_SRC;
    end

    always_ff @(posedge clk_slow_i or posedge arst) begin
        if (arst) r_q <= '{state: ST_SRC};
        else      r_q <= r_d;
    end

    assign cpu_rst_o   = (r_q.state != ST_RUN);
    assign sys_rst_o   = (r_q.state == ST_SRC) || (r_q.state == ST_SYSRST) ||
                         (r_q.state == ST_WD_RST);
    assign osc_pd_o    = (r_q.state == ST_SRC) || (r_q.state == ST_SYSRST) ||
                         (r_q.state == ST_HOLD);
    assign wdt_en_o    = wdt_en;
    assign cause_por_o = cause.por;
    assign cause_ext_o = cause.ext;
    assign cause_wdt_o = cause.wdt;

endmodule

// File: rtl/rsc_checker.sv
module rsc_checker (
    input logic clk_i,
    input logic arst_i,
    input logic src_i,
    input logic cpu_rst_i,
    input logic osc_pd_i,
    input logic sys_rst_i,
    input logic wdt_en_i,
    input logic cause_por_i,
    input logic cause_ext_i,
    input logic cause_wdt_i
);

    AST_SYS_IMPLIES_CPU: assert property (@(posedge clk_i) disable iff (arst_i)
        sys_rst_i |-> cpu_rst_i);                                        // R3

    AST_OSC_IMPLIES_CPU: assert property (@(posedge clk_i) disable iff (arst_i)
        osc_pd_i |-> cpu_rst_i);                                         // R4

    AST_OSCON_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (arst_i)
        $fell(osc_pd_i) |=> (!cpu_rst_i || osc_pd_i));                   // R5

    AST_RUN_KEEPS_OSC: assert property (@(posedge clk_i) disable iff (arst_i)
        (!cpu_rst_i && !src_i) |=> !osc_pd_i);                           // R6

    AST_WDR_TWO_CYCLES: assert property (@(posedge clk_i) disable iff (arst_i)
        ($rose(cpu_rst_i) && !osc_pd_i) |=> cpu_rst_i);                   // R6

    AST_WDT_STICKY: assert property (@(posedge clk_i) disable iff (arst_i)
        (wdt_en_i && !src_i) |=> wdt_en_i);                              // R7

    AST_WDT_DISABLED: assert property (@(posedge clk_i) disable iff (arst_i)
        (!wdt_en_i && !src_i && !cpu_rst_i) |=> !cpu_rst_i);             // R8

    AST_SOURCE_RESTART: assert property (@(posedge clk_i) disable iff (arst_i)
        src_i |=> (osc_pd_i && sys_rst_i && cpu_rst_i));                  // R10

    AST_CAUSE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (arst_i)
        cause_wdt_i |-> (!cause_por_i && !cause_ext_i));                  // R11

endmodule

bind rst_seq_ctrl rsc_checker u_rsc_checker (
    .clk_i       (clk_slow_i),
    .arst_i      (arst),
    .src_i       (src_s),
    .cpu_rst_i   (cpu_rst_o),
    .osc_pd_i    (osc_pd_o),
    .sys_rst_i   (sys_rst_o),
    .wdt_en_i    (wdt_en_o),
    .cause_por_i (cause_por_o),
    .cause_ext_i (cause_ext_o),
    .cause_wdt_i (cause_wdt_o)
);

// File: tb/rst_seq_ctrl_test.sv
module rst_seq_ctrl_test;

    localparam int HOLD = 2048;
    localparam int SYNC = 2;

    typedef struct packed {
        logic       cpu;
        logic       osc;
        logic       sys;
        logic [3:0] req;
    } exp_t;

    logic clk = 1'b0;
    logic por_coarse, por_fine, ext_rst, wdt_exp, wdt_arm;
    logic cpu_rst, sys_rst, osc_pd, wdt_en, c_por, c_ext, c_wdt;

    int checks   = 0;
    int failures = 0;
    exp_t exp_q[$];

    always #10 clk = ~clk;   // 50 MHz

    rst_seq_ctrl #(.HOLDOFF_CYCLES(HOLD), .SYNC_STAGES(SYNC)) uut (
        .clk_slow_i   (clk),
        .por_coarse_i (por_coarse),
        .por_fine_i   (por_fine),
        .ext_rst_i    (ext_rst),
        .wdt_expire_i (wdt_exp),
        .wdt_arm_i    (wdt_arm),
        .cpu_rst_o    (cpu_rst),
        .sys_rst_o    (sys_rst),
        .osc_pd_o     (osc_pd),
        .wdt_en_o     (wdt_en),
        .cause_por_o  (c_por),
        .cause_ext_o  (c_ext),
        .cause_wdt_o  (c_wdt)
    );

    // Monitor: one expected output triple per falling edge while the queue holds items.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if ({cpu_rst, osc_pd, sys_rst} !== {e.cpu, e.osc, e.sys}) begin
                    failures++;
                    $display("FAIL R%0d cpu/osc/sys actual=%b expected=%b at %0t",
                             e.req, {cpu_rst, osc_pd, sys_rst}, {e.cpu, e.osc, e.sys}, $time);
                end
            end
        end
    end

    task automatic push(input logic cpu, input logic osc, input logic sys,
                        input int req, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back('{cpu, osc, sys, 4'(req)});
    endtask

    // Full supply/pin release sequence: R3 reset tail, R4 hold-off, R5 oscillator-on cycle.
    task automatic expect_full();
        push(1, 1, 1, 3, SYNC + 1);
        push(1, 1, 0, 4, HOLD);
        push(1, 0, 0, 5, 1);
        push(0, 0, 0, 5, 2);
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        @(negedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic pulse_wdt(input int n);
        wdt_exp = 1'b1;
        repeat (n) @(negedge clk);
        #1 wdt_exp = 1'b0;
    endtask

    task automatic arm();
        wdt_arm = 1'b1;
        @(negedge clk);
        #1 wdt_arm = 1'b0;
    endtask

    // Pin reset held for 5 sampled cycles: two synchronizer cycles, then source phase.
    task automatic ext_pulse(input logic osc_before, input int req);
        ext_rst = 1'b1;
        push(1'b1 & (osc_before | 1'b0) | !osc_before ? osc_before : 1'b0, osc_before, 0, req, 0);
        if (osc_before) push(1, 1, 0, req, SYNC);
        else            push(0, 0, 0, req, SYNC);
        push(1, 1, 1, req, 5 - SYNC);
        repeat (5) @(negedge clk);
        #1 ext_rst = 1'b0;
    endtask

    initial begin
        por_coarse = 1'b0; por_fine = 1'b0; ext_rst = 1'b0;
        wdt_exp = 1'b0; wdt_arm = 1'b0;
        #5 por_coarse = 1'b1;
        repeat (4) @(negedge clk);
        #2;
        // R1: coarse detector alone holds everything in reset
        check("R1 cpu/osc/sys in reset", {cpu_rst, osc_pd, sys_rst}, 3'b111);
        check("R7 wdt_en after reset", {2'b00, wdt_en}, 3'b000);
        @(negedge clk);
        #1 por_coarse = 1'b0;
        expect_full();
        drain();
        check("R11 cause after supply reset", {c_por, c_ext, c_wdt}, 3'b100);

        // R8: expiry with the path disabled does nothing
        push(0, 0, 0, 8, 3);
        pulse_wdt(1);
        drain();
        check("R8 cause unchanged", {c_por, c_ext, c_wdt}, 3'b100);

        // R7: arm strobe enables the path
        arm();
        #1 check("R7 wdt_en after arm", {2'b00, wdt_en}, 3'b001);

        // R6: watchdog reset, oscillator stays on
        push(1, 0, 1, 6, 1);
        push(1, 0, 0, 6, 1);
        push(0, 0, 0, 6, 1);
        pulse_wdt(1);
        drain();
        check("R7 wdt_en kept after watchdog reset", {2'b00, wdt_en}, 3'b001);
        check("R11 cause after watchdog reset", {c_por, c_ext, c_wdt}, 3'b001);

        // R9: expiry held through the watchdog sequence triggers only one reset
        push(1, 0, 1, 9, 1);
        push(1, 0, 0, 9, 1);
        push(0, 0, 0, 9, 2);
        pulse_wdt(3);
        drain();

        // R2: pin reset gives the full sequence and clears the enable
        arm();
        ext_pulse(1'b0, 2);
        // R10: let the hold-off run for a while, then restart it with the pin
        push(1, 1, 1, 10, SYNC + 1);
        push(1, 1, 0, 10, 100);
        drain();
        ext_pulse(1'b1, 10);
        expect_full();
        drain();
        check("R7 wdt_en cleared by pin reset", {2'b00, wdt_en}, 3'b000);
        check("R2 cause after pin reset", {c_por, c_ext, c_wdt}, 3'b010);

        // R1/R11: precise detector alone; supply reset clears the watchdog flag
        arm();
        push(1, 0, 1, 11, 1);
        push(1, 0, 0, 11, 1);
        push(0, 0, 0, 11, 1);
        pulse_wdt(1);
        drain();
        check("R11 cause before supply reset", {c_por, c_ext, c_wdt}, 3'b001);
        por_fine = 1'b1;
        push(1, 1, 1, 1, 3);
        repeat (3) @(negedge clk);
        #1 por_fine = 1'b0;
        expect_full();
        drain();
        check("R11 cause after precise detector", {c_por, c_ext, c_wdt}, 3'b100);
        check("R7 wdt_en cleared by supply reset", {2'b00, wdt_en}, 3'b000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all-requirements actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule